// File: doc/BRIEF.md
# Double-Buffered USB IN Endpoint Transmit Buffer

This block is the transmit side of one IN endpoint in a full-speed USB device controller. Software loads packet bytes one at a time through a byte-write port into two ping-pong packet buffers. The serial interface engine then drains them when the host sends IN tokens. A buffer is armed for transmission in one of two ways: its byte count reaches the maximum packet size, or software marks it as a short packet by writing the short-packet bit. The short-packet bit also arms an empty buffer, which gives a zero-length packet.

For each IN token the block answers, one cycle later, with either a data response carrying the packet length or a NAK. The engine then pops the bytes of the oldest armed buffer in the order they were written. A buffer is released only when the engine reports a handshake from the host. Without that handshake, the next IN token sends the same packet again from its first byte.

An 8-bit control/status register holds five bits:
- a service-request flag,
- a sticky packet-sent flag,
- a flush strobe,
- a sticky underrun flag,
- the short-packet bit.

An interrupt request combines the two sticky flags under an enable input.

Top module: `usb_in_ep_buffer`

## Requirements
- R1: After reset the status register reads 0x01, `irq` is 0, `resp_data` and `resp_nak` are 0, and `overflow_flag` is 0.
- R2: Status bit 0 (service request) reads 1 while at most one buffer is armed, and reads 0 while both buffers are armed.
- R3: A buffer is armed when MAX_PKT bytes have been written to it, or when software writes 1 to status bit 7 (this covers zero bytes). An IN token to an armed buffer gives a `resp_data` pulse one cycle later, with `resp_len` equal to the byte count. Each `tx_pop` then advances `tx_data` through the bytes in the order they were written.
- R4: Every IN token produces exactly one of `resp_data` or `resp_nak`, one cycle later. The answer is `resp_nak` whenever no buffer is armed.
- R5: A `host_ack` pulse after a data response releases that buffer and sets status bit 1. Only a software write of 1 to bit 1 clears bit 1. While bit 1 is set, the next armed buffer is still answered with data.
- R6: Without `host_ack`, the buffer stays armed, and the next IN token returns the same length and restarts at the first byte.
- R7: `irq` equals `irq_en` AND (status bit 1 OR status bit 3).
- R8: Writing 1 to status bit 2, or pulsing `cfg_event`, empties both buffers. Afterwards bit 0 reads 1, bit 7 reads 0, and the next IN token is NAKed. Bit 2 always reads 0.
- R9: A `tx_pop` when no byte of the current packet remains (or when no packet is being sent) sets status bit 3. Writing 1 to bit 3 clears it.
- R10: Status bits 6 to 4 read 0, and writing them changes nothing.
- R11: Status bit 7 reads 1 while a buffer armed as a short packet is still unacknowledged, and returns to 0 when `host_ack` releases it.
- R12: A byte written while both buffers are armed is discarded and leaves the buffer contents unchanged. It also sets `overflow_flag`, which stays set until reset.
- R13: Packets are sent in the order they were armed, alternating between the two buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Byte write strobe from software |
| wr_data | input | 8 | Byte to append to the fill buffer |
| csr_wr | input | 1 | Status register write strobe |
| csr_wdata | input | 8 | Status register write data |
| csr_rdata | output | 8 | Status register read value |
| cfg_event | input | 1 | Configuration or interface change pulse; flushes both buffers |
| in_token | input | 1 | IN token received pulse |
| resp_data | output | 1 | Data response pulse, one cycle after the token |
| resp_nak | output | 1 | NAK response pulse, one cycle after the token |
| resp_len | output | LEN_W | Length of the packet being answered |
| tx_pop | input | 1 | Engine consumes the current byte |
| tx_data | output | 8 | Current byte of the packet being sent |
| host_ack | input | 1 | Handshake from host received for the packet in flight |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| overflow_flag | output | 1 | Sticky flag for a dropped byte write |

## Verification
The assertions check the following on every cycle:
- NAK and data responses never occur together.
- An empty endpoint always NAKs, and an armed one always sends data.
- The packet-sent flag holds until its clear write.
- The interrupt tracks its sources.
- A flush leaves the service bit set and the short bit clear.
- A pop with nothing in flight raises underrun.
- The overflow flag never falls.

Only the bench scenarios can show the following:
- Byte ordering and correct packet lengths.
- Retransmission from the first byte after a missing handshake.
- Strict ping-pong order.
- That a dropped byte never appears in any later packet.

// File: rtl/usb_in_ep_pkg.sv
// Shared constants and types for the IN endpoint transmit buffer.
// Assumes exactly two packet buffers used alternately.
package usb_in_ep_pkg;
    localparam int NUM_BUF       = 2;
    localparam int CSR_SVC_BIT   = 0;
    localparam int CSR_SENT_BIT  = 1;
    localparam int CSR_FLUSH_BIT = 2;
    localparam int CSR_UNDR_BIT  = 3;
    localparam int CSR_SHORT_BIT = 7;

    typedef enum logic {
        TX_IDLE   = 1'b0,
        TX_ACTIVE = 1'b1
    } tx_state_e;
endpackage

// File: rtl/usb_in_ep_pktbuf.sv
// One packet buffer: byte storage plus fill count, armed flag and short flag.
// Assumes the caller only asserts wr_en / short_mark while the buffer is not
// armed; flush and release both return it to the empty state.
module usb_in_ep_pktbuf #(
    parameter  int MAX_PKT = 64,
    localparam int LEN_W   = $clog2(MAX_PKT + 1),
    localparam int ADDR_W  = $clog2(MAX_PKT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              short_mark,
    input  logic              release_buf,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [LEN_W-1:0]  count,
    output logic              ready,
    output logic              short_pkt
);
    logic [7:0] mem [MAX_PKT];
    logic       last_byte;

    assign last_byte = wr_en && (count == LEN_W'(MAX_PKT - 1));
    assign rd_data   = mem[rd_addr];

    // Store an incoming byte at the current fill position.
    always_ff @(posedge clk) begin
        if (wr_en && !ready) begin
            mem[count[ADDR_W-1:0]] <= wr_data;
        end
    end

    // Track fill level and the armed / short state of the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count     <= '0;
            ready     <= 1'b0;
            short_pkt <= 1'b0;
        end else if (flush || release_buf) begin
            count     <= '0;
            ready     <= 1'b0;
            short_pkt <= 1'b0;
        end else if (!ready) begin
            if (wr_en) begin
                count <= count + LEN_W'(1);
            end
            if (last_byte) begin
                ready <= 1'b1;
            end else if (short_mark) begin
                ready     <= 1'b1;
                short_pkt <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/usb_in_ep_txeng.sv
// Drain side: answers IN tokens with data or NAK, walks the read pointer
// through the oldest armed buffer, releases it on a host handshake and flags
// pops that find no byte. Priority per cycle: flush, token, handshake, pop.
module usb_in_ep_txeng #(
    parameter  int MAX_PKT = 64,
    localparam int LEN_W   = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             in_token,
    input  logic             tx_pop,
    input  logic             host_ack,
    input  logic [1:0]       buf_ready,
    input  logic [LEN_W-1:0] drain_len,
    output logic             drain_sel,
    output logic             sending,
    output logic             resp_data,
    output logic             resp_nak,
    output logic [LEN_W-1:0] resp_len,
    output logic [LEN_W-1:0] rd_ptr,
    output logic [1:0]       release_vec,
    output logic             underrun
);
    import usb_in_ep_pkg::*;

    tx_state_e state;
    logic      pkt_avail;
    logic      ack_ok;

    assign sending   = (state == TX_ACTIVE);
    assign pkt_avail = buf_ready[drain_sel];
    assign ack_ok    = host_ack && sending && !flush && !in_token;
    assign underrun  = tx_pop && !(sending && (rd_ptr < drain_len));

    // One release line per buffer, raised for the buffer being drained.
    always_comb begin
        for (int b = 0; b < NUM_BUF; b++) begin
            release_vec[b] = ack_ok && (drain_sel == 1'(b));
        end
    end

    // Token response, drain pointer and buffer selection sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= TX_IDLE;
            drain_sel <= 1'b0;
            rd_ptr    <= '0;
            resp_data <= 1'b0;
            resp_nak  <= 1'b0;
            resp_len  <= '0;
        end else begin
            resp_data <= 1'b0;
            resp_nak  <= 1'b0;
            if (flush) begin
                state     <= TX_IDLE;
                drain_sel <= 1'b0;
                rd_ptr    <= '0;
                resp_nak  <= in_token;
            end else if (in_token) begin
                if (pkt_avail) begin
                    resp_data <= 1'b1;
                    resp_len  <= drain_len;
                    state     <= TX_ACTIVE;
                    rd_ptr    <= '0;
                end else begin
                    resp_nak <= 1'b1;
                end
            end else if (ack_ok) begin
                state     <= TX_IDLE;
                drain_sel <= ~drain_sel;
                rd_ptr    <= '0;
            end else if (tx_pop && !underrun) begin
                rd_ptr <= rd_ptr + LEN_W'(1);
            end
        end
    end
endmodule

// File: rtl/usb_in_ep_status.sv
// Status register: sticky sent and underrun flags with write-one-to-clear,
// sticky overflow flag, read value assembly and interrupt request.
// Assumes set events win over a clear written in the same cycle.
module usb_in_ep_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       csr_wr,
    input  logic [7:0] csr_wdata,
    input  logic       pkt_sent,
    input  logic       underrun,
    input  logic       overflow_evt,
    input  logic [1:0] buf_ready,
    input  logic [1:0] buf_short,
    input  logic       irq_en,
    output logic [7:0] csr_rdata,
    output logic       irq,
    output logic       overflow_flag
);
    import usb_in_ep_pkg::*;

    logic sent_q;
    logic undr_q;
    logic sent_clr;
    logic undr_clr;
    logic unused_wbits;

    assign sent_clr     = csr_wr && csr_wdata[CSR_SENT_BIT];
    assign undr_clr     = csr_wr && csr_wdata[CSR_UNDR_BIT];
    assign unused_wbits = ^{csr_wdata[7:4], csr_wdata[2], csr_wdata[0]};

    // Sticky flags: hardware sets, software clears by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent_q        <= 1'b0;
            undr_q        <= 1'b0;
            overflow_flag <= 1'b0;
        end else begin
            if (pkt_sent) begin
                sent_q <= 1'b1;
            end else if (sent_clr) begin
                sent_q <= 1'b0;
            end
            if (underrun) begin
                undr_q <= 1'b1;
            end else if (undr_clr) begin
                undr_q <= 1'b0;
            end
            if (overflow_evt) begin
                overflow_flag <= 1'b1;
            end
        end
    end

    // Read value: flush and reserved positions always return zero.
    always_comb begin
        csr_rdata                = '0;
        csr_rdata[CSR_SVC_BIT]   = !(&buf_ready);
        csr_rdata[CSR_SENT_BIT]  = sent_q;
        csr_rdata[CSR_UNDR_BIT]  = undr_q;
        csr_rdata[CSR_SHORT_BIT] = |(buf_ready & buf_short);
    end

    // Interrupt request from either sticky source.
    assign irq = irq_en && (sent_q || undr_q);
endmodule

// File: rtl/usb_in_ep_buffer.sv
// Top of the double-buffered IN endpoint. Routes software byte writes into
// the current fill buffer, flips to the other buffer once one is armed,
// decodes flush and short-packet requests and joins the drain engine and
// status register. Assumes one software access per cycle.
module usb_in_ep_buffer #(
    parameter  int MAX_PKT = 64,
    localparam int LEN_W   = $clog2(MAX_PKT + 1),
    localparam int ADDR_W  = $clog2(MAX_PKT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    input  logic             csr_wr,
    input  logic [7:0]       csr_wdata,
    output logic [7:0]       csr_rdata,
    input  logic             cfg_event,
    input  logic             in_token,
    output logic             resp_data,
    output logic             resp_nak,
    output logic [LEN_W-1:0] resp_len,
    input  logic             tx_pop,
    output logic [7:0]       tx_data,
    input  logic             host_ack,
    input  logic             irq_en,
    output logic             irq,
    output logic             overflow_flag
);
    import usb_in_ep_pkg::*;

    logic             fill_sel;
    logic             flush_now;
    logic             short_req;
    logic             byte_ok;
    logic             short_ok;
    logic             fill_done;
    logic             overflow_evt;
    logic [1:0]       buf_ready;
    logic [1:0]       buf_short;
    logic [1:0]       wr_en_v;
    logic [1:0]       short_v;
    logic [1:0]       release_vec;
    logic [LEN_W-1:0] buf_count [NUM_BUF];
    logic [7:0]       buf_rdata [NUM_BUF];
    logic             drain_sel;
    logic             tx_sending;
    logic [LEN_W-1:0] rd_ptr;
    logic             underrun;

    assign flush_now    = (csr_wr && csr_wdata[CSR_FLUSH_BIT]) || cfg_event;
    assign short_req    = csr_wr && csr_wdata[CSR_SHORT_BIT];
    assign byte_ok      = wr_valid && !flush_now && !buf_ready[fill_sel];
    assign short_ok     = short_req && !flush_now && !buf_ready[fill_sel];
    assign overflow_evt = wr_valid && !flush_now && buf_ready[fill_sel];
    assign fill_done    = (byte_ok && (buf_count[fill_sel] == LEN_W'(MAX_PKT - 1)))
                          || short_ok;
    assign tx_data      = buf_rdata[drain_sel];

    // Fill buffer selection: alternate each time the fill buffer is armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_sel <= 1'b0;
        end else if (flush_now) begin
            fill_sel <= 1'b0;
        end else if (fill_done) begin
            fill_sel <= ~fill_sel;
        end
    end

    for (genvar gi = 0; gi < NUM_BUF; gi++) begin : g_buf
        assign wr_en_v[gi] = byte_ok  && (fill_sel == 1'(gi));
        assign short_v[gi] = short_ok && (fill_sel == 1'(gi));

        usb_in_ep_pktbuf #(.MAX_PKT(MAX_PKT)) u_pktbuf (
            .clk         (clk),
            .rst_n       (rst_n),
            .flush       (flush_now),
            .wr_en       (wr_en_v[gi]),
            .wr_data     (wr_data),
            .short_mark  (short_v[gi]),
            .release_buf (release_vec[gi]),
            .rd_addr     (rd_ptr[ADDR_W-1:0]),
            .rd_data     (buf_rdata[gi]),
            .count       (buf_count[gi]),
            .ready       (buf_ready[gi]),
            .short_pkt   (buf_short[gi])
        );
    end

    usb_in_ep_txeng #(.MAX_PKT(MAX_PKT)) u_txeng (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush_now),
        .in_token    (in_token),
        .tx_pop      (tx_pop),
        .host_ack    (host_ack),
        .buf_ready   (buf_ready),
        .drain_len   (buf_count[drain_sel]),
        .drain_sel   (drain_sel),
        .sending     (tx_sending),
        .resp_data   (resp_data),
        .resp_nak    (resp_nak),
        .resp_len    (resp_len),
        .rd_ptr      (rd_ptr),
        .release_vec (release_vec),
        .underrun    (underrun)
    );

    usb_in_ep_status u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .csr_wr        (csr_wr),
        .csr_wdata     (csr_wdata),
        .pkt_sent      (|release_vec),
        .underrun      (underrun),
        .overflow_evt  (overflow_evt),
        .buf_ready     (buf_ready),
        .buf_short     (buf_short),
        .irq_en        (irq_en),
        .csr_rdata     (csr_rdata),
        .irq           (irq),
        .overflow_flag (overflow_flag)
    );
endmodule

// File: rtl/usb_in_ep_checker.sv
// Property checker for the IN endpoint buffer, attached by bind.
// Observes ports and the armed / sending / flush signals of the top.
module usb_in_ep_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_token,
    input logic       tx_pop,
    input logic       flush_now,
    input logic       irq_en,
    input logic       irq,
    input logic       resp_data,
    input logic       resp_nak,
    input logic       svc_bit,
    input logic       sent_bit,
    input logic       undr_bit,
    input logic       short_bit,
    input logic       sent_w1c,
    input logic       overflow_flag,
    input logic       sending,
    input logic [1:0] buf_ready
);
    assert_resp_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_data && resp_nak));

    assert_nak_when_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_token && (buf_ready == 2'b00)) |=> resp_nak);

    assert_data_when_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_token && !flush_now && (buf_ready != 2'b00)) |=> resp_data);

    assert_sent_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sent_bit && !sent_w1c) |=> sent_bit);

    assert_irq_raised_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && (sent_bit || undr_bit)) |-> irq);

    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_now |=> (svc_bit && !short_bit));

    assert_idle_pop_underrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && !sending) |=> undr_bit);

    assert_no_overflow_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_flag |=> overflow_flag);
endmodule

bind usb_in_ep_buffer usb_in_ep_checker i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_token      (in_token),
    .tx_pop        (tx_pop),
    .flush_now     (flush_now),
    .irq_en        (irq_en),
    .irq           (irq),
    .resp_data     (resp_data),
    .resp_nak      (resp_nak),
    .svc_bit       (csr_rdata[0]),
    .sent_bit      (csr_rdata[1]),
    .undr_bit      (csr_rdata[3]),
    .short_bit     (csr_rdata[7]),
    .sent_w1c      (csr_wr && csr_wdata[1]),
    .overflow_flag (overflow_flag),
    .sending       (tx_sending),
    .buf_ready     (buf_ready)
);

// File: tb/test_usb_in_ep_buffer.sv
module test_usb_in_ep_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_PKT    = 64;
    localparam int LEN_W      = $clog2(MAX_PKT + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_valid = 1'b0;
    logic [7:0]       wr_data = '0;
    logic             csr_wr = 1'b0;
    logic [7:0]       csr_wdata = '0;
    logic [7:0]       csr_rdata;
    logic             cfg_event = 1'b0;
    logic             in_token = 1'b0;
    logic             resp_data;
    logic             resp_nak;
    logic [LEN_W-1:0] resp_len;
    logic             tx_pop = 1'b0;
    logic [7:0]       tx_data;
    logic             host_ack = 1'b0;
    logic             irq_en = 1'b0;
    logic             irq;
    logic             overflow_flag;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model state, built from the requirements.
    byte unsigned fill_q[$];
    byte unsigned pend_q[$];
    int           pend_len[$];
    bit           pend_short[$];
    bit           sent_m = 1'b0;
    bit           undr_m = 1'b0;

    usb_in_ep_buffer #(.MAX_PKT(MAX_PKT)) i_usb_in_ep_buffer (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .cfg_event(cfg_event), .in_token(in_token), .resp_data(resp_data),
        .resp_nak(resp_nak), .resp_len(resp_len), .tx_pop(tx_pop),
        .tx_data(tx_data), .host_ack(host_ack), .irq_en(irq_en), .irq(irq),
        .overflow_flag(overflow_flag)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_csr();
        bit any_short = 1'b0;
        foreach (pend_short[i]) any_short |= pend_short[i];
        return {24'd0, any_short, 3'b000, undr_m, 1'b0, sent_m, (pend_len.size() < 2)};
    endfunction

    function automatic void arm_packet(input bit is_short);
        pend_len.push_back(fill_q.size());
        pend_short.push_back(is_short);
        foreach (fill_q[i]) pend_q.push_back(fill_q[i]);
        fill_q.delete();
    endfunction

    function automatic void model_flush();
        fill_q.delete();
        pend_q.delete();
        pend_len.delete();
        pend_short.delete();
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic put_byte(input byte unsigned b);
        wr_valid = 1'b1;
        wr_data  = b;
        step();
        wr_valid = 1'b0;
        if (pend_len.size() < 2) begin
            fill_q.push_back(b);
            if (fill_q.size() == MAX_PKT) arm_packet(1'b0);
        end
    endtask

    task automatic csr_write(input byte unsigned v);
        csr_wr    = 1'b1;
        csr_wdata = v;
        step();
        csr_wr = 1'b0;
        if (v[1]) sent_m = 1'b0;
        if (v[3]) undr_m = 1'b0;
        if (v[2]) model_flush();
        else if (v[7] && pend_len.size() < 2) arm_packet(1'b1);
    endtask

    task automatic pulse_cfg();
        cfg_event = 1'b1;
        step();
        cfg_event = 1'b0;
        model_flush();
    endtask

    task automatic send_token(input string tag);
        in_token = 1'b1;
        step();
        in_token = 1'b0;
        if (pend_len.size() > 0) begin
            chk({tag, " data response"}, int'(resp_data), 1);
            chk({tag, " no nak"}, int'(resp_nak), 0);
            chk({tag, " length"}, int'(resp_len), pend_len[0]);
        end else begin
            chk({tag, " nak response"}, int'(resp_nak), 1);
            chk({tag, " no data"}, int'(resp_data), 0);
        end
    endtask

    task automatic drain(input bit do_ack);
        for (int i = 0; i < pend_len[0]; i++) begin
            chk("R3/R13 byte order", int'(tx_data), int'(pend_q[i]));
            tx_pop = 1'b1;
            step();
            tx_pop = 1'b0;
        end
        if (do_ack) begin
            host_ack = 1'b1;
            step();
            host_ack = 1'b0;
            for (int i = 0; i < pend_len[0]; i++) void'(pend_q.pop_front());
            void'(pend_len.pop_front());
            void'(pend_short.pop_front());
            sent_m = 1'b1;
            chk("R5 sent flag after handshake", int'(csr_rdata[1]), 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 status after reset", int'(csr_rdata), 8'h01);
        chk("R1 irq after reset", int'(irq), 0);
        chk("R1 no response after reset", int'(resp_data | resp_nak), 0);
        chk("R1 overflow after reset", int'(overflow_flag), 0);

        // R3 / R11 zero-length packet
        csr_write(8'h80);
        chk("R11 short bit armed", int'(csr_rdata[7]), 1);
        chk("R2 one armed keeps service", int'(csr_rdata[0]), 1);
        send_token("R3 zero-length");
        drain(1'b1);
        chk("R11 short bit after handshake", int'(csr_rdata[7]), 0);
        irq_en = 1'b1;
        #1;
        chk("R7 irq with sent flag", int'(irq), 1);
        irq_en = 1'b0;
        #1;
        chk("R7 irq gated by enable", int'(irq), 0);

        // R4 nak with sent flag set and nothing armed
        send_token("R4 empty endpoint");

        // R10 reserved bits
        csr_write(8'h70);
        chk("R10 reserved bits read zero", int'(csr_rdata[6:4]), 0);
        chk("R10 reserved write no effect", int'(csr_rdata), exp_csr());
        csr_write(8'h02);
        chk("R5 sent flag cleared by write", int'(csr_rdata[1]), 0);

        // R8 flush by software and by configuration event
        for (int i = 0; i < 3; i++) put_byte(byte'(8'h30 + i));
        csr_write(8'h80);
        put_byte(8'h55);
        csr_write(8'h04);
        chk("R8 flush bit reads zero", int'(csr_rdata[2]), 0);
        chk("R8 status after flush", int'(csr_rdata), 8'h01);
        send_token("R8 after flush");
        put_byte(8'h11);
        csr_write(8'h80);
        pulse_cfg();
        chk("R8 status after cfg event", int'(csr_rdata), 8'h01);
        send_token("R8 after cfg event");

        // Random phase
        irq_en = 1'b1;
        for (int it = 0; it < 700; it++) begin
            int r;
            r = int'($urandom % 20);
            if (r < 12) begin
                put_byte(byte'($urandom));
            end else if (r < 14) begin
                csr_write(8'h80);
            end else if (r == 14) begin
                csr_write(8'h72);
            end else if (r < 19) begin
                send_token("R4/R13 random token");
                if (pend_len.size() > 0) drain(($urandom % 4) != 0);
            end else if (($urandom % 4) == 0) begin
                pulse_cfg();
            end
            chk("R2/R11 random status", int'(csr_rdata), exp_csr());
            chk("R7 random irq", int'(irq), int'(sent_m | undr_m));
        end

        // R12 / R6 / R13 two full packets, overflow, retransmit
        csr_write(8'h06);
        for (int i = 0; i < MAX_PKT; i++) put_byte(byte'(i));
        chk("R2 one full packet", int'(csr_rdata[0]), 1);
        for (int i = 0; i < MAX_PKT; i++) put_byte(byte'(8'h80 + i));
        chk("R2 both armed", int'(csr_rdata[0]), 0);
        put_byte(8'hEE);
        chk("R12 overflow flagged", int'(overflow_flag), 1);
        chk("R12 service still clear", int'(csr_rdata[0]), 0);
        send_token("R3 full packet");
        drain(1'b0);
        send_token("R6 retransmit");
        chk("R6 retransmit first byte", int'(tx_data), 0);
        drain(1'b1);
        send_token("R5 send with sent flag set");
        drain(1'b1);
        chk("R12 overflow sticky", int'(overflow_flag), 1);

        // R9 underrun
        tx_pop = 1'b1;
        step();
        tx_pop = 1'b0;
        undr_m = 1'b1;
        chk("R9 underrun set", int'(csr_rdata[3]), 1);
        csr_write(8'h02);
        chk("R7 irq from underrun", int'(irq), 1);
        csr_write(8'h08);
        chk("R9 underrun cleared", int'(csr_rdata[3]), 0);
        chk("R7 irq dropped", int'(irq), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule